// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block steps a small datapath through block string operations: copying, loading into the accumulator, storing from the accumulator, comparing two memory elements, and scanning memory for an accumulator value. It holds a source pointer, a destination pointer and an element counter. It issues one memory request per element over a request/acknowledge handshake. After each acknowledged element it moves the pointers forward or backward by the element size.

A start pulse loads the pointers, the counter and the operation settings. A repeat selector picks one of four forms: a single element, a repeat that runs until the counter empties, or one of two conditional repeats. The conditional repeats also stop on the zero flag that a compare or scan produces. The memory side returns the source and destination data with the acknowledge, and the block forms the zero flag from them itself. A one-cycle done pulse marks the end of the sequence.

Top module: `strrep_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low, and the source pointer, destination pointer, count and zero flag all read 0.
- R2: A start while idle loads src_ptr, dst_ptr and count from the init inputs on that clock edge. Unless R6 applies, mem_req is high from the next cycle until the sequence ends.
- R3: op_sel encodes 0 copy, 1 load, 2 store, 3 compare, 4 scan. Source access (mem_src_en) is used by copy, load and compare. Destination access (mem_dst_en, always an extra-segment address) is used by copy, store, compare and scan. mem_src_addr and mem_dst_addr equal the current pointers.
- R4: On each acknowledged element, every pointer in use moves by 1 for bytes (word_sel=0) or by 2 for words (word_sel=1). It moves up when dir_down=0 and down when dir_down=1, wrapping modulo 2^16. A pointer that is not in use keeps its value.
- R5: rep_sel encodes 0 single, 1 repeat, 2 repeat-while-equal, 3 repeat-while-not-equal. With rep_sel nonzero, count drops by one on every acknowledged element. Repeat (1) runs exactly the initial count of elements.
- R6: With rep_sel nonzero and a count init of 0, no memory request is made and done is high in the cycle after start.
- R7: With rep_sel 0, exactly one element runs and count keeps its loaded value.
- R8: Compare sets the zero flag when source minus destination is zero. Scan sets it when accumulator minus destination is zero. Only the low 8 bits are tested for bytes. Copy, load and store leave the zero flag unchanged.
- R9: Repeat-while-equal also ends after a compare or scan element that leaves the zero flag 0. Repeat-while-not-equal also ends after one that leaves it 1. For copy, load and store both behave as repeat (1).
- R10: done is a single-cycle pulse in the cycle after the final acknowledge (or after start, under R6), and busy is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op_sel | input | 3 | Operation: 0 copy, 1 load, 2 store, 3 compare, 4 scan |
| rep_sel | input | 2 | Repeat form: 0 single, 1 repeat, 2 while-equal, 3 while-not-equal |
| dir_down | input | 1 | 1 steps pointers downward |
| word_sel | input | 1 | 1 selects 16-bit elements, 0 bytes |
| src_init | input | 16 | Source pointer load value |
| dst_init | input | 16 | Destination pointer load value |
| cnt_init | input | 16 | Count load value |
| acc_in | input | 16 | Accumulator value for scan, loaded at start |
| mem_req | output | 1 | Element request, held until acknowledged |
| mem_ack | input | 1 | Element completed; data inputs valid |
| mem_src_en | output | 1 | Request reads the source element |
| mem_dst_en | output | 1 | Request touches the extra-segment destination element |
| mem_src_addr | output | 16 | Source offset |
| mem_dst_addr | output | 16 | Destination offset |
| rd_src | input | 16 | Source data returned with mem_ack |
| rd_dst | input | 16 | Destination data returned with mem_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| zf | output | 1 | Zero flag from the last compare or scan |

## Verification
The assertions assume that mem_ack is only meaningful while mem_req is high. They also assume that start is ignored, not queued, while busy is high. The bench raises mem_ack only during a request and releases it in the next cycle. It issues start only after it has seen busy low. Returned data is drawn so that equal and unequal elements both occur, including byte elements that differ only in the upper byte. This keeps both conditional repeat forms reaching early termination as well as count exhaustion.

// File: rtl/strrep_pkg.sv
`timescale 1ns/1ps
package strrep_pkg;
  typedef enum logic [2:0] {
    OP_COPY  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_CMP   = 3'd3,
    OP_SCAN  = 3'd4
  } str_op_e;

  typedef enum logic [1:0] {
    RP_ONCE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strrep_step.sv
`timescale 1ns/1ps
module strrep_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         en_i,
  input  logic         word_i,
  input  logic         down_i,
  output logic [W-1:0] ptr_o
);
  localparam logic [W-1:0] BYTE_D = W'(1);
  localparam logic [W-1:0] WORD_D = W'(2);

  logic [W-1:0] delta;

  always_comb begin
    delta = word_i ? WORD_D : BYTE_D;
    if (!en_i)       ptr_o = ptr_i;
    else if (down_i) ptr_o = ptr_i - delta;
    else             ptr_o = ptr_i + delta;
  end
endmodule

// File: rtl/strrep_zero.sv
`timescale 1ns/1ps
module strrep_zero #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         word_i,
  output logic         zero_o
);
  localparam int BW = 8;

  logic [W-1:0] diff;

  always_comb begin
    diff   = a_i - b_i;
    zero_o = word_i ? (diff == '0) : (diff[BW-1:0] == '0);
  end
endmodule

// File: rtl/strrep_fsm.sv
`timescale 1ns/1ps
module strrep_fsm
  import strrep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  rep_e rep_in,
  input  logic cnt_in_zero,
  input  logic ack,
  input  rep_e rep_q,
  input  logic cmp_like,
  input  logic zf_next,
  input  logic cnt_next_zero,
  output logic busy,
  output logic req,
  output logic done,
  output logic load,
  output logic step
);
  seq_state_e state_q, state_d;
  logic       stop;

  always_comb begin
    stop = (rep_q == RP_ONCE) || cnt_next_zero
        || (cmp_like && (rep_q == RP_EQ) && !zf_next)
        || (cmp_like && (rep_q == RP_NE) && zf_next);
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ((rep_in != RP_ONCE) && cnt_in_zero) ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        if (ack) begin
          step = 1'b1;
          if (stop) state_d = ST_FIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
  assign req  = (state_q == ST_XFER);
  assign done = (state_q == ST_FIN);
endmodule

// File: rtl/strrep_seq.sv
`timescale 1ns/1ps
module strrep_seq
  import strrep_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic [1:0]    rep_sel,
  input  logic          dir_down,
  input  logic          word_sel,
  input  logic [PW-1:0] src_init,
  input  logic [PW-1:0] dst_init,
  input  logic [PW-1:0] cnt_init,
  input  logic [DW-1:0] acc_in,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic          mem_src_en,
  output logic          mem_dst_en,
  output logic [PW-1:0] mem_src_addr,
  output logic [PW-1:0] mem_dst_addr,
  input  logic [DW-1:0] rd_src,
  input  logic [DW-1:0] rd_dst,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] src_ptr,
  output logic [PW-1:0] dst_ptr,
  output logic [PW-1:0] count,
  output logic          zf
);
  localparam int NPTR = 2;

  str_op_e       op_q;
  rep_e          rep_q;
  logic          down_q, word_q;
  logic [DW-1:0] acc_q;
  logic [PW-1:0] ptr_q   [NPTR];
  logic [PW-1:0] ptr_nx  [NPTR];
  logic [PW-1:0] ptr_ini [NPTR];
  logic          ptr_use [NPTR];
  logic [PW-1:0] cnt_q, cnt_nx;
  logic          zf_q, zf_nx, zero_hit, cmp_like;
  logic [DW-1:0] cmp_a;
  logic          load, step, ack_ok;

  always_comb begin
    ptr_use[0] = (op_q == OP_COPY) || (op_q == OP_LOAD) || (op_q == OP_CMP);
    ptr_use[1] = (op_q != OP_LOAD);
    ptr_ini[0] = src_init;
    ptr_ini[1] = dst_init;
    cmp_like   = (op_q == OP_CMP) || (op_q == OP_SCAN);
    cmp_a      = (op_q == OP_SCAN) ? acc_q : rd_src;
    zf_nx      = cmp_like ? zero_hit : zf_q;
    cnt_nx     = (rep_q != RP_ONCE) ? (cnt_q - 1'b1) : cnt_q;
    ack_ok     = mem_req && mem_ack;
  end

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      strrep_step #(.W(PW)) u_step (
        .ptr_i (ptr_q[g]),
        .en_i  (ptr_use[g]),
        .word_i(word_q),
        .down_i(down_q),
        .ptr_o (ptr_nx[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q[g] <= '0;
        else if (load) ptr_q[g] <= ptr_ini[g];
        else if (step) ptr_q[g] <= ptr_nx[g];
      end
    end
  endgenerate

  strrep_zero #(.W(DW)) u_zero (
    .a_i   (cmp_a),
    .b_i   (rd_dst),
    .word_i(word_q),
    .zero_o(zero_hit)
  );

  strrep_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rep_in       (rep_e'(rep_sel)),
    .cnt_in_zero  (cnt_init == '0),
    .ack          (ack_ok),
    .rep_q        (rep_q),
    .cmp_like     (cmp_like),
    .zf_next      (zf_nx),
    .cnt_next_zero(cnt_nx == '0),
    .busy         (busy),
    .req          (mem_req),
    .done         (done),
    .load         (load),
    .step         (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_COPY;
      rep_q  <= RP_ONCE;
      down_q <= 1'b0;
      word_q <= 1'b0;
      acc_q  <= '0;
    end else if (load) begin
      op_q   <= str_op_e'(op_sel);
      rep_q  <= rep_e'(rep_sel);
      down_q <= dir_down;
      word_q <= word_sel;
      acc_q  <= acc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_init;
    else if (step) cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    zf_q <= 1'b0;
    else if (step) zf_q <= zf_nx;
  end

  assign mem_src_en   = mem_req && ptr_use[0];
  assign mem_dst_en   = mem_req && ptr_use[1];
  assign mem_src_addr = ptr_q[0];
  assign mem_dst_addr = ptr_q[1];
  assign src_ptr      = ptr_q[0];
  assign dst_ptr      = ptr_q[1];
  assign count        = cnt_q;
  assign zf           = zf_q;
endmodule

// File: rtl/strrep_chk.sv
`timescale 1ns/1ps
module strrep_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    rep_sel,
  input logic [PW-1:0] cnt_init,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [PW-1:0] src_ptr,
  input logic [PW-1:0] dst_ptr,
  input logic [PW-1:0] count,
  input logic          zf,
  input logic [2:0]    op_q,
  input logic [1:0]    rep_q
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(src_ptr) && $stable(dst_ptr)));

  a_r5_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && rep_q != 2'd0) |=> (count == $past(count) - 1'b1));

  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rep_sel != 2'd0 && cnt_init == '0) |=> (done && !mem_req));

  a_r7_single_once: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && rep_q == 2'd0) |=> ($stable(count) && done));

  a_r8_zf_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && op_q < 3'd3) |=> $stable(zf));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind strrep_seq strrep_chk #(.PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .rep_sel (rep_sel),
  .cnt_init(cnt_init),
  .busy    (busy),
  .done    (done),
  .mem_req (mem_req),
  .mem_ack (mem_ack),
  .src_ptr (src_ptr),
  .dst_ptr (dst_ptr),
  .count   (count),
  .zf      (zf),
  .op_q    (op_q),
  .rep_q   (rep_q)
);

// File: tb/test_strrep_seq.sv
`timescale 1ns/1ps
module test_strrep_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  rep_sel = '0;
  logic        dir_down = 1'b0, word_sel = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0, acc_in = '0;
  logic        mem_req, mem_ack = 1'b0, mem_src_en, mem_dst_en;
  logic [15:0] mem_src_addr, mem_dst_addr;
  logic [15:0] rd_src = '0, rd_dst = '0;
  logic        busy, done, zf;
  logic [15:0] src_ptr, dst_ptr, count;

  int n_chk = 0, n_bad = 0, eq_pct = 50;
  bit finished = 0;
  bit m_zf = 0;

  always #2 clk = ~clk;

  strrep_seq i_strrep_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_zero(input logic [15:0] a, input logic [15:0] b, input bit w);
    logic [15:0] d = a - b;
    return w ? (d == 16'h0) : (d[7:0] == 8'h0);
  endfunction

  task automatic run(input int op, input int rp, input bit dn, input bit w,
                     input logic [15:0] s0, input logic [15:0] d0,
                     input logic [15:0] c0, input logic [15:0] acc, input int exp_it);
    logic [15:0] ms = s0, md = d0, mc = c0, st, dv, a;
    bit use_s = (op == 0 || op == 1 || op == 3);
    bit use_d = (op != 1);
    bit cmpl = (op == 3 || op == 4);
    bit stop;
    int it = 0;
    st = w ? 16'd2 : 16'd1;
    @(negedge clk);
    start = 1; op_sel = 3'(op); rep_sel = 2'(rp); dir_down = dn; word_sel = w;
    src_init = s0; dst_init = d0; cnt_init = c0; acc_in = acc;
    @(negedge clk);
    start = 0;
    chk(src_ptr == s0 && dst_ptr == d0 && count == c0, "R2", "load", int'(count), int'(c0));
    if (rp != 0 && c0 == 0) begin
      chk(done && !mem_req, "R6", "zero count done", int'({done, mem_req}), 2);
    end else begin
      forever begin
        chk(mem_req == 1, "R2", "req", int'(mem_req), 1);
        chk(mem_src_en == use_s && mem_dst_en == use_d, "R3", "enables",
            int'({mem_src_en, mem_dst_en}), int'({use_s, use_d}));
        chk(mem_src_addr == ms && mem_dst_addr == md, "R3", "addr",
            int'(mem_dst_addr), int'(md));
        repeat ($urandom % 3) @(negedge clk);
        a = (op == 4) ? acc : 16'($urandom);
        if (($urandom % 100) < eq_pct) dv = w ? a : {8'($urandom), a[7:0]};
        else dv = a ^ {8'($urandom), 8'(1 + $urandom % 255)};
        if (!w && ($urandom % 2)) dv[15:8] = ~a[15:8];
        rd_src = a; rd_dst = dv; mem_ack = 1;
        if (use_s) ms = dn ? ms - st : ms + st;
        if (use_d) md = dn ? md - st : md + st;
        if (rp != 0) mc = mc - 1;
        if (cmpl) m_zf = m_zero(a, dv, w);
        it++;
        stop = (rp == 0) || (mc == 0) || (cmpl && rp == 2 && !m_zf) || (cmpl && rp == 3 && m_zf);
        @(negedge clk);
        mem_ack = 0;
        chk(src_ptr == ms && dst_ptr == md, "R4", "pointers", int'(dst_ptr), int'(md));
        chk(count == mc, (rp == 0) ? "R7" : "R5", "count", int'(count), int'(mc));
        chk(zf == m_zf, "R8", "zf", int'(zf), int'(m_zf));
        chk(done == stop, "R9", "stop", int'(done), int'(stop));
        if (done || it > 70000) break;
      end
      if (exp_it >= 0) chk(it == exp_it, "R9", "iterations", it, exp_it);
    end
    @(negedge clk);
    chk(!busy && !done, "R10", "done pulse", int'({busy, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "ctl reset", int'({busy, done, mem_req}), 0);
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0 && zf == 0, "R1", "reg reset",
        int'(count), 0);
    rst_n = 1;
    run(1, 1, 0, 0, 16'h10, 16'h20, 16'd0, 16'h0, 0);          // R6
    run(0, 0, 0, 1, 16'h100, 16'h200, 16'd5, 16'h0, 1);        // R7
    run(2, 1, 1, 1, 16'h0, 16'h1, 16'd3, 16'h0, 3);            // R4 R5 wrap down
    run(0, 2, 0, 0, 16'hFFFF, 16'h8, 16'd4, 16'h0, 4);         // R9 copy ignores zf
    eq_pct = 100;
    run(3, 2, 0, 0, 16'h40, 16'h80, 16'd4, 16'h0, 4);          // R9 all equal
    eq_pct = 0;
    run(3, 2, 0, 1, 16'h40, 16'h80, 16'd4, 16'h0, 1);          // R9 first mismatch
    run(4, 3, 1, 0, 16'h5, 16'h90, 16'd5, 16'h1234, 5);        // R9 never equal
    eq_pct = 100;
    run(4, 3, 0, 0, 16'h5, 16'h90, 16'd5, 16'h00AB, 1);        // R9 R8 byte scan
    eq_pct = 50;
    for (int k = 0; k < 80; k++)
      run($urandom % 5, $urandom % 4, 1'($urandom), 1'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom % 7), 16'($urandom), -1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd2718);
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule